// File: doc/BRIEF.md
# Two-Pass Grid FFT Engine

This block computes a fixed-point forward FFT of N complex samples (N = 64 by default, or 16) by treating a frame as an R-by-R grid (R = 8, or 4). One fully parallel R-point radix-2 decimation-in-time core is shared between all the small transforms. In the first pass the core transforms each of the R columns, one column per clock, and every result is multiplied by an inter-pass twiddle factor before it is written back. In the second pass the core transforms each of the R rows, again one per clock. The full transform therefore costs 2R core cycles instead of N/2·log2(N) butterfly steps, and it needs only the hardware of a single small core.

Samples stream in with a valid strobe and a ready signal. Results stream out in natural bin order with a valid strobe and an end-of-frame marker. Two frame buffers alternate, so one frame can load while the previous frame is being transformed and read out. Every butterfly stage halves its result, so the output equals the DFT divided by N, and full-scale data cannot overflow.

Top module: `fft_grid_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, outValid and outLast are low and inReady is high.
- R2: A sample is taken on every rising edge where inValid and inReady are both high. The N samples a frame takes, counted from 0 in arrival order, are x[0] to x[N-1]. The R columns of the grid are the sample indices that are equal modulo R.
- R3: For inputs whose real and imaginary parts lie within ±0.7 (±22938 LSB), each output part lies within 128 LSB (2^-8) of the exact DFT divided by N. The exact DFT is X[k] = Σ x[n]·e^(−j2πnk/N). Parts are 16-bit signed, with 32768 LSB equal to 1.0.
- R4: A frame's results are bins 0 to N−1 in increasing order, on N consecutive cycles with outValid high. outValid is low in the cycle after the last bin.
- R5: outLast is high in exactly the cycle that carries bin N−1.
- R6: inReady goes low only while two complete frames are held whose output has not finished. Frames leave in the order in which they arrived.
- R7: While inReady is low, the values on inValid, inRe and inIm have no effect on any later result.
- R8: With POINTS = 16, the engine works on a 4-by-4 grid with a 4-point core and meets R2 to R5 for N = 16.
- R9: A frame whose samples are all −1.0 real (0x8000) and 0 imaginary gives exactly −32768 in the real part of bin 0. Every other output part of that frame is exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample present |
| inReady | output | 1 | Engine can take a sample this cycle |
| inRe | input | 16 | Input real part, signed Q1.15 |
| inIm | input | 16 | Input imaginary part, signed Q1.15 |
| outValid | output | 1 | Output bin present |
| outLast | output | 1 | Output bin is bin N−1 |
| outRe | output | 16 | Output real part, signed Q1.15 |
| outIm | output | 16 | Output imaginary part, signed Q1.15 |

## Verification
The hardest state to reach from the ports is the one where both frame buffers are occupied. In that state one frame is still being computed or drained, a second frame has loaded completely, and a third frame is waiting. The bench gets there by streaming three random frames back to back with inValid held high throughout. The third frame then arrives before the first has been read out, and inReady drops. During that stall the bench keeps inValid high and drives random junk, so any sample taken by mistake would shift the third frame and be caught by the spectrum comparison. Exact all-minus-one frames and single impulses at chosen positions check saturation, bin ordering and the column mapping in both the 64-point and the 16-point builds.

// File: rtl/fft_grid_pkg.sv
package fft_grid_pkg;
  localparam int SW    = 16;            // sample part width
  localparam int TAB   = 64;            // twiddle circle resolution (largest N)
  localparam int AW    = $clog2(TAB);   // widest frame index
  localparam int LRMAX = 3;             // widest grid lane index

  typedef struct packed {
    logic signed [SW-1:0] re;
    logic signed [SW-1:0] im;
  } cplx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic           load;
    logic           loadSel;
    logic [AW-1:0]  loadAddr;
    logic           passOne;
    logic           passTwo;
    logic [LRMAX-1:0] lane;
    logic           cmpSel;
    logic           emit;
    logic           emitLast;
    logic [AW-1:0]  emitBin;
  } strobe_t;

  // cosine over the first quarter of the circle, rounded to Q1.15
  function automatic logic signed [SW-1:0] quarterCos(input int i);
    case (i)
      0: return 16'sd32767;   1: return 16'sd32610;   2: return 16'sd32138;
      3: return 16'sd31357;   4: return 16'sd30274;   5: return 16'sd28899;
      6: return 16'sd27246;   7: return 16'sd25330;   8: return 16'sd23170;
      9: return 16'sd20788;  10: return 16'sd18205;  11: return 16'sd15447;
     12: return 16'sd12540;  13: return 16'sd9512;   14: return 16'sd6393;
     15: return 16'sd3212;
      default: return '0;
    endcase
  endfunction

  function automatic logic signed [SW-1:0] cosAt(input int p);
    if (p <= TAB/4)        return quarterCos(p);
    else if (p <= TAB/2)   return -quarterCos(TAB/2 - p);
    else if (p <= 3*TAB/4) return -quarterCos(p - TAB/2);
    else                   return quarterCos(TAB - p);
  endfunction

  // e^(-j*2*pi*idx/TAB)
  function automatic cplx_t twiddle(input int idx);
    cplx_t w;
    w.re = cosAt(idx % TAB);
    w.im = -cosAt((idx + 3*TAB/4) % TAB);
    return w;
  endfunction

  function automatic logic signed [SW-1:0] roundSat(input logic signed [2*SW:0] v);
    logic signed [2*SW:0] r;
    logic signed [2*SW:0] hi;
    logic signed [2*SW:0] lo;
    hi = (2*SW+1)'((1 <<< (SW-1)) - 1);
    lo = -(2*SW+1)'(1 <<< (SW-1));
    r  = (v + (2*SW+1)'(1 <<< (SW-2))) >>> (SW-1);
    if (r > hi) return hi[SW-1:0];
    if (r < lo) return lo[SW-1:0];
    return r[SW-1:0];
  endfunction

  // multiply by twiddle index; index 0 passes the value through exactly
  function automatic cplx_t cmul(input cplx_t a, input int idx);
    cplx_t w;
    cplx_t y;
    logic signed [2*SW:0] pr;
    logic signed [2*SW:0] pi;
    if (idx % TAB == 0) return a;
    w  = twiddle(idx);
    pr = a.re * w.re - a.im * w.im;
    pi = a.re * w.im + a.im * w.re;
    y.re = roundSat(pr);
    y.im = roundSat(pi);
    return y;
  endfunction

  // radix-2 butterfly leg with halving
  function automatic cplx_t halfLeg(input cplx_t a, input cplx_t b, input logic sub);
    logic signed [SW:0] sr;
    logic signed [SW:0] si;
    cplx_t y;
    sr = sub ? a.re - b.re : a.re + b.re;
    si = sub ? a.im - b.im : a.im + b.im;
    y.re = sr[SW:1];
    y.im = si[SW:1];
    return y;
  endfunction

  function automatic int bitRev(input int v, input int bits);
    int r;
    r = 0;
    for (int i = 0; i < bits; i++) if (((v >> i) & 1) != 0) r |= 1 << (bits - 1 - i);
    return r;
  endfunction
endpackage

// File: rtl/fft_par_core.sv
module fft_par_core
  import fft_grid_pkg::*;
#(
  parameter int RAD = 8
) (
  input  cplx_t xin  [RAD],
  output cplx_t xout [RAD]
);
  localparam int LR = $clog2(RAD);

  cplx_t st [LR+1][RAD];

  for (genvar i = 0; i < RAD; i++) begin : g_rev
    assign st[0][i] = xin[bitRev(i, LR)];
    assign xout[i]  = st[LR][i];
  end

  for (genvar s = 0; s < LR; s++) begin : g_stage
    localparam int H = 1 << s;
    for (genvar b = 0; b < RAD/2; b++) begin : g_bfly
      localparam int J   = b % H;
      localparam int TOP = (b / H) * 2 * H + J;
      localparam int TW  = J * (TAB / (2 * H));
      cplx_t prod;
      assign prod            = cmul(st[s][TOP+H], TW);
      assign st[s+1][TOP]    = halfLeg(st[s][TOP], prod, 1'b0);
      assign st[s+1][TOP+H]  = halfLeg(st[s][TOP], prod, 1'b1);
    end
  end
endmodule

// File: rtl/fft_grid_dp.sv
module fft_grid_dp
  import fft_grid_pkg::*;
#(
  parameter int POINTS = 64,
  parameter int RAD    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              cmd,
  input  logic signed [SW-1:0] inRe,
  input  logic signed [SW-1:0] inIm,
  output logic                 outValid,
  output logic                 outLast,
  output logic signed [SW-1:0] outRe,
  output logic signed [SW-1:0] outIm
);
  localparam int LR    = $clog2(RAD);
  localparam int LA    = $clog2(POINTS);
  localparam int TSTEP = TAB / POINTS;

  cplx_t mem [2][POINTS];
  cplx_t coreIn  [RAD];
  cplx_t coreOut [RAD];
  cplx_t twProd  [RAD];
  logic [LA-1:0] colAddr [RAD];
  logic [LA-1:0] rowAddr [RAD];
  logic [LA-1:0] emitAddr;

  for (genvar m = 0; m < RAD; m++) begin : g_lane
    assign colAddr[m] = {LR'(m), cmd.lane[LR-1:0]};   // n1 + R*m
    assign rowAddr[m] = {cmd.lane[LR-1:0], LR'(m)};   // m + R*k2
    assign coreIn[m]  = mem[cmd.cmpSel][cmd.passTwo ? rowAddr[m] : colAddr[m]];
    assign twProd[m]  = cmul(coreOut[m], (int'(cmd.lane[LR-1:0]) * m * TSTEP) % TAB);
  end

  fft_par_core #(.RAD(RAD)) u_core (.xin(coreIn), .xout(coreOut));

  // bin k = k2 + R*k1 sits at address k1 + R*k2
  assign emitAddr = {cmd.emitBin[LR-1:0], cmd.emitBin[2*LR-1:LR]};

  always_ff @(posedge clk) begin
    if (cmd.load) mem[cmd.loadSel][cmd.loadAddr[LA-1:0]] <= '{re: inRe, im: inIm};
    for (int m = 0; m < RAD; m++) begin
      if (cmd.passOne) mem[cmd.cmpSel][colAddr[m]] <= twProd[m];
      if (cmd.passTwo) mem[cmd.cmpSel][rowAddr[m]] <= coreOut[m];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
      outRe    <= '0;
      outIm    <= '0;
    end else begin
      outValid <= cmd.emit;
      outLast  <= cmd.emit && cmd.emitLast;
      if (cmd.emit) begin
        outRe <= mem[cmd.cmpSel][emitAddr].re;
        outIm <= mem[cmd.cmpSel][emitAddr].im;
      end
    end
  end
endmodule

// File: rtl/fft_grid_ctrl.sv
module fft_grid_ctrl
  import fft_grid_pkg::*;
#(
  parameter int POINTS = 64,
  parameter int RAD    = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output logic    inReady,
  output strobe_t cmd
);
  localparam int LR = $clog2(RAD);
  localparam int LA = $clog2(POINTS);

  typedef enum logic [1:0] {S_IDLE, S_COLS, S_ROWS, S_EMIT} phase_t;

  phase_t        phase;
  logic [1:0]    full;
  logic          wrSel;
  logic          cmpSel;
  logic [LA-1:0] wrCnt;
  logic [LA-1:0] cnt;
  logic          accept;

  assign inReady = !full[wrSel];
  assign accept  = inValid && inReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= S_IDLE;
      full   <= '0;
      wrSel  <= 1'b0;
      cmpSel <= 1'b0;
      wrCnt  <= '0;
      cnt    <= '0;
    end else begin
      if (accept) begin
        if (wrCnt == LA'(POINTS-1)) begin
          wrCnt       <= '0;
          full[wrSel] <= 1'b1;
          wrSel       <= ~wrSel;
        end else begin
          wrCnt <= wrCnt + 1'b1;
        end
      end
      unique case (phase)
        S_IDLE: if (full[cmpSel]) begin
          phase <= S_COLS;
          cnt   <= '0;
        end
        S_COLS: if (cnt == LA'(RAD-1)) begin
          phase <= S_ROWS;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        S_ROWS: if (cnt == LA'(RAD-1)) begin
          phase <= S_EMIT;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        S_EMIT: if (cnt == LA'(POINTS-1)) begin
          phase        <= S_IDLE;
          cnt          <= '0;
          full[cmpSel] <= 1'b0;
          cmpSel       <= ~cmpSel;
        end else cnt <= cnt + 1'b1;
        default: phase <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd          = '0;
    cmd.load     = accept;
    cmd.loadSel  = wrSel;
    cmd.loadAddr = AW'(wrCnt);
    cmd.passOne  = (phase == S_COLS);
    cmd.passTwo  = (phase == S_ROWS);
    cmd.lane     = LRMAX'(cnt[LR-1:0]);
    cmd.cmpSel   = cmpSel;
    cmd.emit     = (phase == S_EMIT);
    cmd.emitLast = (cnt == LA'(POINTS-1));
    cmd.emitBin  = AW'(cnt);
  end
endmodule

// File: rtl/fft_grid_engine.sv
module fft_grid_engine
  import fft_grid_pkg::*;
#(
  parameter int POINTS = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic signed [SW-1:0] inRe,
  input  logic signed [SW-1:0] inIm,
  output logic                 outValid,
  output logic                 outLast,
  output logic signed [SW-1:0] outRe,
  output logic signed [SW-1:0] outIm
);
  localparam int RAD = (POINTS == 16) ? 4 : 8;

  strobe_t cmd;

  fft_grid_ctrl #(.POINTS(POINTS), .RAD(RAD)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .cmd(cmd)
  );

  fft_grid_dp #(.POINTS(POINTS), .RAD(RAD)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .inRe(inRe), .inIm(inIm),
    .outValid(outValid), .outLast(outLast), .outRe(outRe), .outIm(outIm)
  );
endmodule

// File: rtl/fft_grid_engine_chk.sv
module fft_grid_engine_chk #(
  parameter int POINTS = 64
) (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inReady,
  input logic outValid,
  input logic outLast
);
  int sampCnt;
  int beatCnt;
  int loaded;
  int done;
  int pending;

  assign pending = loaded - done;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampCnt <= 0;
      beatCnt <= 0;
      loaded  <= 0;
      done    <= 0;
    end else begin
      if (inValid && inReady) begin
        if (sampCnt == POINTS-1) begin
          sampCnt <= 0;
          loaded  <= loaded + 1;
        end else sampCnt <= sampCnt + 1;
      end
      if (outValid) beatCnt <= outLast ? 0 : beatCnt + 1;
      if (outLast) done <= done + 1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rstN |=> (!outValid && !outLast && inReady));
  // R5
  last_valid_chk: assert property (@(posedge clk) disable iff (!rstN) outLast |-> outValid);
  // R4
  beats_contig_chk: assert property (@(posedge clk) disable iff (!rstN) (outValid && !outLast) |=> outValid);
  // R4
  gap_after_last_chk: assert property (@(posedge clk) disable iff (!rstN) outLast |=> !outValid);
  // R5
  beat_count_chk: assert property (@(posedge clk) disable iff (!rstN) outLast |-> (beatCnt == POINTS-1));
  // R6
  ready_free_chk: assert property (@(posedge clk) disable iff (!rstN) (pending < 2) |-> inReady);
  // R6
  ready_stall_chk: assert property (@(posedge clk) disable iff (!rstN) (pending == 2 && !outLast) |-> !inReady);
endmodule

bind fft_grid_engine fft_grid_engine_chk #(.POINTS(POINTS)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outLast(outLast)
);

// File: tb/tb_fft_grid_engine.sv
module tb_fft_grid_engine;
  localparam int CLK_PERIOD = 10;
  localparam int BIG = 64;
  localparam int SMALL = 16;
  localparam real TOL = 128.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int selPts = BIG;
  logic drvValid = 1'b0;
  logic signed [15:0] drvRe = '0;
  logic signed [15:0] drvIm = '0;

  logic rdyB, vB, lB, rdyS, vS, lS;
  logic signed [15:0] reB, imB, reS, imS;

  fft_grid_engine #(.POINTS(BIG)) dut (
    .clk(clk), .rstN(rstN), .inValid(drvValid && selPts == BIG), .inReady(rdyB),
    .inRe(drvRe), .inIm(drvIm), .outValid(vB), .outLast(lB), .outRe(reB), .outIm(imB));

  fft_grid_engine #(.POINTS(SMALL)) dut16 (
    .clk(clk), .rstN(rstN), .inValid(drvValid && selPts == SMALL), .inReady(rdyS),
    .inRe(drvRe), .inIm(drvIm), .outValid(vS), .outLast(lS), .outRe(reS), .outIm(imS));

  logic selReady, selValid, selLast;
  logic signed [15:0] selRe, selIm;
  assign selReady = (selPts == BIG) ? rdyB : rdyS;
  assign selValid = (selPts == BIG) ? vB : vS;
  assign selLast  = (selPts == BIG) ? lB : lS;
  assign selRe    = (selPts == BIG) ? reB : reS;
  assign selIm    = (selPts == BIG) ? imB : imS;

  int nChecks = 0;
  int nFails = 0;
  bit sawStall = 0;
  int stimRe [4][64];
  int stimIm [4][64];
  int gotRe [4][64];
  int gotIm [4][64];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic fillConst(input int f, input int re, input int im);
    for (int n = 0; n < 64; n++) begin stimRe[f][n] = re; stimIm[f][n] = im; end
  endtask

  task automatic fillImpulse(input int f, input int pos, input int re, input int im);
    fillConst(f, 0, 0);
    stimRe[f][pos] = re;
    stimIm[f][pos] = im;
  endtask

  task automatic fillRandom(input int f);
    for (int n = 0; n < 64; n++) begin
      stimRe[f][n] = int'($urandom % 45877) - 22938;
      stimIm[f][n] = int'($urandom % 45877) - 22938;
    end
  endtask

  task automatic driveFrames(input int nf, input int pts);
    for (int f = 0; f < nf; f++) begin
      for (int n = 0; n < pts; n++) begin
        @(negedge clk);
        while (!selReady) begin
          drvValid = 1'b1;
          drvRe = 16'($urandom);
          drvIm = 16'($urandom);
          sawStall = 1;
          @(negedge clk);
        end
        drvValid = 1'b1;
        drvRe = 16'(stimRe[f][n]);
        drvIm = 16'(stimIm[f][n]);
      end
    end
    @(negedge clk);
    drvValid = 1'b0;
  endtask

  task automatic collectFrames(input int nf, input int pts);
    for (int f = 0; f < nf; f++) begin
      @(negedge clk);
      while (!selValid) @(negedge clk);
      for (int k = 0; k < pts; k++) begin
        if (k > 0) @(negedge clk);
        check(selValid == 1'b1, "R4", $sformatf("outValid frame %0d bin %0d", f, k), int'(selValid), 1);
        check(selLast == (k == pts-1), "R5", $sformatf("outLast frame %0d bin %0d", f, k), int'(selLast), int'(k == pts-1));
        gotRe[f][k] = int'(selRe);
        gotIm[f][k] = int'(selIm);
      end
      @(negedge clk);
      check(selValid == 1'b0, "R4", $sformatf("outValid after last, frame %0d", f), int'(selValid), 0);
    end
  endtask

  task automatic runFrames(input int nf, input int pts);
    fork
      driveFrames(nf, pts);
      collectFrames(nf, pts);
    join
  endtask

  task automatic compareDft(input int f, input int pts, input string req);
    real ang, er, ei, dr, di;
    for (int k = 0; k < pts; k++) begin
      er = 0.0;
      ei = 0.0;
      for (int n = 0; n < pts; n++) begin
        ang = -2.0 * 3.14159265358979 * real'(n * k) / real'(pts);
        er += real'(stimRe[f][n]) * $cos(ang) - real'(stimIm[f][n]) * $sin(ang);
        ei += real'(stimRe[f][n]) * $sin(ang) + real'(stimIm[f][n]) * $cos(ang);
      end
      er = er / real'(pts);
      ei = ei / real'(pts);
      dr = real'(gotRe[f][k]) - er;
      di = real'(gotIm[f][k]) - ei;
      if (dr < 0.0) dr = -dr;
      if (di < 0.0) di = -di;
      check(dr <= TOL, req, $sformatf("re frame %0d bin %0d", f, k), gotRe[f][k], int'(er));
      check(di <= TOL, req, $sformatf("im frame %0d bin %0d", f, k), gotIm[f][k], int'(ei));
    end
  endtask

  task automatic checkMinusOne(input int f, input int pts, input string req);
    for (int k = 0; k < pts; k++) begin
      check(gotRe[f][k] == ((k == 0) ? -32768 : 0), req, $sformatf("exact re bin %0d", k), gotRe[f][k], (k == 0) ? -32768 : 0);
      check(gotIm[f][k] == 0, req, $sformatf("exact im bin %0d", k), gotIm[f][k], 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog R4 actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (4) @(negedge clk);
    // R1: reset state for both builds
    check(vB == 1'b0 && lB == 1'b0, "R1", "outValid/outLast 64 in reset", int'(vB), 0);
    check(rdyB == 1'b1, "R1", "inReady 64 in reset", int'(rdyB), 1);
    check(vS == 1'b0 && rdyS == 1'b1, "R1", "16-point idle in reset", int'(vS), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rdyB == 1'b1 && vB == 1'b0, "R1", "64 after reset", int'(rdyB), 1);

    // R2: impulses at chosen positions exercise the column mapping
    selPts = BIG;
    fillImpulse(0, 0, 16384, 0);
    fillImpulse(1, 5, -12000, 9000);
    fillImpulse(2, 63, 20000, 0);
    runFrames(3, BIG);
    compareDft(0, BIG, "R2");
    compareDft(1, BIG, "R2");
    compareDft(2, BIG, "R2");

    // R9: full-scale negative DC, exact result
    fillConst(0, -32768, 0);
    runFrames(1, BIG);
    checkMinusOne(0, BIG, "R9");

    // R3: random frames in isolation
    fillRandom(0);
    runFrames(1, BIG);
    compareDft(0, BIG, "R3");

    // R6 / R7: three random frames back to back, junk driven while stalled
    sawStall = 0;
    fillRandom(0);
    fillRandom(1);
    fillRandom(2);
    runFrames(3, BIG);
    check(sawStall == 1, "R6", "inReady dropped with two frames held", int'(sawStall), 1);
    compareDft(0, BIG, "R6");
    compareDft(1, BIG, "R7");
    compareDft(2, BIG, "R7");
    @(negedge clk);
    check(rdyB == 1'b1, "R6", "inReady back after drain", int'(rdyB), 1);

    // R8: 16-point build
    selPts = SMALL;
    fillImpulse(0, 3, 16384, -8192);
    fillRandom(1);
    fillConst(2, -32768, 0);
    runFrames(3, SMALL);
    compareDft(0, SMALL, "R8");
    compareDft(1, SMALL, "R8");
    checkMinusOne(2, SMALL, "R8");
    sawStall = 0;
    fillRandom(0);
    fillRandom(1);
    fillRandom(2);
    runFrames(3, SMALL);
    check(sawStall == 1, "R8", "16-point stall seen", int'(sawStall), 1);
    compareDft(0, SMALL, "R8");
    compareDft(1, SMALL, "R8");
    compareDft(2, SMALL, "R8");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule